// File: doc/BRIEF.md
# Low-Power Escape Command Decoder

This block watches the two single-ended low-power levels of one serial lane. It runs on the system clock and oversamples both lines. Each line first passes through a two-flop synchronizer. A sequencer then waits for the fixed series of line states that opens escape mode.

Once escape mode is open, the block recovers command bits without any clock from the sender. A bit is taken each time the lines leave the all-low spacer state, because that is the moment the XOR of the two lines rises. After eight bits the command byte is reported and sorted into one of three classes:
- ultra-low-power entry;
- a supported trigger;
- unsupported.

Bits that arrive after a command are dropped quietly until the lines return to stop. Ultra-low-power state is held until the exit pattern appears. A broken command is reported as an error, and the sequencer falls back to a known state.

Top module: `esc_cmd_decoder`

## Requirements
- R1: After reset every output is low. A change on the line inputs reaches the outputs through the two-flop synchronizer: the command pulse rises at the third rising clock edge after the line change that completes a command.
- R2: Escape mode opens only when the line states {dp,dn} = 11, 10, 00, 01, 00 are seen in that order. Any other change returns the sequencer to wait for 11, and the bits that follow decode nothing.
- R3: Inside a command, a bit is sampled when the lines leave 00. Line state 10 carries a 1 and 01 carries a 0. The first bit received lands in bit 7 of the command byte.
- R4: After the eighth bit, `cmd_valid` is high for exactly one cycle and `cmd_code` holds the received byte.
- R5: Command 8'h1E raises `ulps_active`. While that flag is high, further line activity produces no command and no error.
- R6: Commands 8'h62, 8'h5D, 8'h21 and 8'hA0 are supported triggers. Bits that follow a command until the next 11 are ignored: no further `cmd_valid` and no `seq_error`.
- R7: Any other byte pulses `cmd_unsupported` together with `cmd_valid`. Its trailing bits are ignored, and the next escape sequence decodes normally.
- R8: Line state 11 during a command (before eight bits) pulses `seq_error`, gives no `cmd_valid`, and returns to stop, from which a new escape entry is accepted.
- R9: A direct hop between 10 and 01 with no 00 spacer during a command pulses `seq_error`. The sequencer then waits for 11.
- R10: `ulps_active` falls only after 10 followed by 11. A 10 followed by 00 keeps the flag high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| dp_in | input | 1 | Positive line low-power level, asynchronous |
| dn_in | input | 1 | Negative line low-power level, asynchronous |
| cmd_valid | output | 1 | One-cycle pulse when a command byte completes |
| cmd_code | output | 8 | Last received command byte |
| cmd_unsupported | output | 1 | Pulses with `cmd_valid` for an unsupported byte |
| ulps_active | output | 1 | High while in ultra-low-power state |
| seq_error | output | 1 | One-cycle pulse on a broken command |

## Verification
The bench sends a byte that is not a palindrome. A decoder that shifted LSB first, or that swapped the meaning of 10 and 01, would report a different code. It times the pulse that completes a command edge by edge, which catches a missing or extra synchronizer stage. It also drives cases a fragile decoder would mishandle:
- bits after a trigger: a fragile decoder would raise a second command or an error;
- a 10 then 00 while in ultra-low-power state: the flag would drop early;
- entry states out of order: a spurious command would decode.

It aborts commands with 11 and with a spacer-less hop, then checks that the next escape decodes. A decoder stuck after an abort fails that check.

// File: rtl/esc_pkg.sv
package esc_pkg;
  localparam int CMD_W = 8;

  // line state packed as {dp, dn}
  localparam logic [1:0] LN_11 = 2'b11;
  localparam logic [1:0] LN_10 = 2'b10;
  localparam logic [1:0] LN_01 = 2'b01;
  localparam logic [1:0] LN_00 = 2'b00;

  localparam logic [CMD_W-1:0] CODE_ULPS = 8'h1E;

  typedef enum logic [3:0] {
    S_WAIT11, S_STOP, S_E1, S_E2, S_E3, S_CMD, S_TRAIL, S_ULPS, S_UEXIT
  } esc_state_e;

  typedef enum logic [1:0] {K_UNSUP, K_ULPS, K_TRIG} cmd_kind_e;

  function automatic cmd_kind_e classify(input logic [CMD_W-1:0] c);
    case (c)
      CODE_ULPS:                      return K_ULPS;
      8'h62, 8'h5D, 8'h21, 8'hA0:     return K_TRIG;
      default:                        return K_UNSUP;
    endcase
  endfunction

  // one-hot mark: dp high carries a 1
  function automatic logic mark_bit(input logic [1:0] ln);
    return ln[1];
  endfunction

  function automatic logic is_mark(input logic [1:0] ln);
    return (ln == LN_10) || (ln == LN_01);
  endfunction
endpackage

// File: rtl/esc_line_sync.sv
module esc_line_sync #(
  parameter int STAGES = 2,
  parameter int WIDTH  = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] stage_q [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) stage_q[i] <= '0;
    end else begin
      stage_q[0] <= d;
      for (int i = 1; i < STAGES; i++) stage_q[i] <= stage_q[i-1];
    end
  end

  assign q = stage_q[STAGES-1];
endmodule

// File: rtl/esc_bit_slicer.sv
module esc_bit_slicer
  import esc_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] ls,
  output logic       line_changed,
  output logic       bit_strobe,
  output logic       bit_val,
  output logic       bad_hop
);
  logic [1:0] ls_prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ls_prev <= LN_00;
    else        ls_prev <= ls;
  end

  // XOR of the lines rises when leaving the 00 spacer
  assign line_changed = (ls != ls_prev);
  assign bit_strobe   = (ls_prev == LN_00) && is_mark(ls);
  assign bit_val      = mark_bit(ls);
  assign bad_hop      = line_changed && is_mark(ls_prev) && is_mark(ls);
endmodule

// File: rtl/esc_seq_fsm.sv
module esc_seq_fsm
  import esc_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       ls,
  input  logic             line_changed,
  input  logic             bit_strobe,
  input  logic             bit_val,
  input  logic             bad_hop,
  output logic             cmd_valid,
  output logic [CMD_W-1:0] cmd_code,
  output logic             cmd_unsupported,
  output logic             seq_error,
  output logic             ulps_active
);
  localparam int CW = $clog2(CMD_W + 1);
  localparam logic [CW-1:0] LAST = CW'(CMD_W - 1);

  esc_state_e       state;
  logic [CW-1:0]    bit_cnt;
  logic [CMD_W-1:0] shreg;
  logic [CMD_W-1:0] sh_next;
  cmd_kind_e        kind_next;

  assign sh_next   = {shreg[CMD_W-2:0], bit_val};
  assign kind_next = classify(sh_next);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state           <= S_WAIT11;
      bit_cnt         <= '0;
      shreg           <= '0;
      cmd_code        <= '0;
      cmd_valid       <= 1'b0;
      cmd_unsupported <= 1'b0;
      seq_error       <= 1'b0;
    end else begin
      cmd_valid       <= 1'b0;
      cmd_unsupported <= 1'b0;
      seq_error       <= 1'b0;
      case (state)
        S_WAIT11: if (ls == LN_11) state <= S_STOP;
        S_STOP: if (line_changed) state <= (ls == LN_10) ? S_E1 : S_WAIT11;
        S_E1: if (line_changed) begin
          if (ls == LN_00)      state <= S_E2;
          else if (ls == LN_11) state <= S_STOP;
          else                  state <= S_WAIT11;
        end
        S_E2: if (line_changed) begin
          if (ls == LN_01)      state <= S_E3;
          else if (ls == LN_11) state <= S_STOP;
          else                  state <= S_WAIT11;
        end
        S_E3: if (line_changed) begin
          if (ls == LN_00) begin
            state   <= S_CMD;
            bit_cnt <= '0;
            shreg   <= '0;
          end else if (ls == LN_11) state <= S_STOP;
          else                      state <= S_WAIT11;
        end
        S_CMD: begin
          if (line_changed && ls == LN_11) begin
            seq_error <= 1'b1;
            state     <= S_STOP;
          end else if (bad_hop) begin
            seq_error <= 1'b1;
            state     <= S_WAIT11;
          end else if (bit_strobe) begin
            shreg <= sh_next;
            if (bit_cnt == LAST) begin
              cmd_code        <= sh_next;
              cmd_valid       <= 1'b1;
              cmd_unsupported <= (kind_next == K_UNSUP);
              state           <= (kind_next == K_ULPS) ? S_ULPS : S_TRAIL;
            end else begin
              bit_cnt <= bit_cnt + 1'b1;
            end
          end
        end
        S_TRAIL: if (line_changed && ls == LN_11) state <= S_STOP;
        S_ULPS:  if (line_changed && ls == LN_10) state <= S_UEXIT;
        S_UEXIT: if (line_changed) state <= (ls == LN_11) ? S_STOP : S_ULPS;
        default: state <= S_WAIT11;
      endcase
    end
  end

  assign ulps_active = (state == S_ULPS) || (state == S_UEXIT);
endmodule

// File: rtl/esc_cmd_decoder.sv
module esc_cmd_decoder
  import esc_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             dp_in,
  input  logic             dn_in,
  output logic             cmd_valid,
  output logic [CMD_W-1:0] cmd_code,
  output logic             cmd_unsupported,
  output logic             ulps_active,
  output logic             seq_error
);
  logic [1:0] ls_sync;
  logic       line_changed;
  logic       bit_strobe;
  logic       bit_val;
  logic       bad_hop;

  esc_line_sync #(.STAGES(SYNC_STAGES), .WIDTH(2)) u_sync (
    .clk(clk), .rst_n(rst_n), .d({dp_in, dn_in}), .q(ls_sync)
  );

  esc_bit_slicer u_slicer (
    .clk(clk), .rst_n(rst_n), .ls(ls_sync),
    .line_changed(line_changed), .bit_strobe(bit_strobe),
    .bit_val(bit_val), .bad_hop(bad_hop)
  );

  esc_seq_fsm u_fsm (
    .clk(clk), .rst_n(rst_n), .ls(ls_sync),
    .line_changed(line_changed), .bit_strobe(bit_strobe),
    .bit_val(bit_val), .bad_hop(bad_hop),
    .cmd_valid(cmd_valid), .cmd_code(cmd_code),
    .cmd_unsupported(cmd_unsupported), .seq_error(seq_error),
    .ulps_active(ulps_active)
  );
endmodule

// File: rtl/esc_cmd_checker.sv
module esc_cmd_checker (
  input logic       clk,
  input logic       rst_n,
  input logic [1:0] ls_sync,
  input logic       bit_strobe,
  input logic       cmd_valid,
  input logic [7:0] cmd_code,
  input logic       cmd_unsupported,
  input logic       ulps_active,
  input logic       seq_error
);
  p_valid_after_strobe_r4: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |-> $past(bit_strobe));

  p_unsup_with_valid_r7: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_unsupported |-> (cmd_valid && cmd_code != 8'h1E));

  p_error_no_valid_r8: assert property (@(posedge clk) disable iff (!rst_n)
    seq_error |-> !cmd_valid);

  p_ulps_code_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ulps_active) |-> (cmd_valid && cmd_code == 8'h1E));

  p_ulps_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (ulps_active && $past(ulps_active)) |-> (!cmd_valid && !seq_error));

  p_ulps_exit_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ulps_active) |-> ($past(ls_sync) == 2'b11));
endmodule

bind esc_cmd_decoder esc_cmd_checker u_chk (
  .clk(clk), .rst_n(rst_n), .ls_sync(ls_sync), .bit_strobe(bit_strobe),
  .cmd_valid(cmd_valid), .cmd_code(cmd_code),
  .cmd_unsupported(cmd_unsupported), .ulps_active(ulps_active),
  .seq_error(seq_error)
);

// File: tb/esc_cmd_decoder_bench.sv
module esc_cmd_decoder_bench;
  localparam int HOLD = 4;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       dp_in = 1'b1;
  logic       dn_in = 1'b1;
  logic       cmd_valid;
  logic [7:0] cmd_code;
  logic       cmd_unsupported;
  logic       ulps_active;
  logic       seq_error;

  int n_checks = 0;
  int n_fail   = 0;
  int n_valid  = 0;
  int n_unsup  = 0;
  int n_err    = 0;
  logic [7:0] last_code = 8'h00;
  bit done = 0;

  always #4 clk = ~clk;

  esc_cmd_decoder u_esc_cmd_decoder (
    .clk(clk), .rst_n(rst_n), .dp_in(dp_in), .dn_in(dn_in),
    .cmd_valid(cmd_valid), .cmd_code(cmd_code),
    .cmd_unsupported(cmd_unsupported), .ulps_active(ulps_active),
    .seq_error(seq_error)
  );

  always @(negedge clk) begin
    if (rst_n) begin
      if (cmd_valid) begin
        n_valid   <= n_valid + 1;
        last_code <= cmd_code;
      end
      if (cmd_unsupported) n_unsup <= n_unsup + 1;
      if (seq_error)       n_err   <= n_err + 1;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic drive(input logic [1:0] ln);
    {dp_in, dn_in} = ln;
    repeat (HOLD) @(negedge clk);
  endtask

  task automatic entry();
    drive(2'b11); drive(2'b10); drive(2'b00); drive(2'b01); drive(2'b00);
  endtask

  task automatic send_bits(input logic [7:0] b, input int nbits);
    for (int i = 7; i > 7 - nbits; i--) begin
      drive(b[i] ? 2'b10 : 2'b01);
      drive(2'b00);
    end
  endtask

  task automatic stop_seq();
    drive(2'b10); drive(2'b11);
  endtask

  task automatic t_reset();
    chk(!cmd_valid && !cmd_unsupported && !ulps_active && !seq_error,
        "R1 reset outputs",
        {cmd_valid, cmd_unsupported, ulps_active, seq_error}, 0);
  endtask

  task automatic t_trigger(input logic [7:0] code);
    int v0 = n_valid; int e0 = n_err; int u0 = n_unsup;
    entry();
    send_bits(code, 8);
    chk(n_valid == v0 + 1, "R4 one valid per trigger", n_valid - v0, 1);
    chk(last_code == code, "R3 R6 trigger code", last_code, code);
    chk(n_unsup == u0, "R6 trigger supported", n_unsup - u0, 0);
    send_bits(8'h55, 8);
    send_bits(8'hC3, 5);
    stop_seq();
    chk(n_valid == v0 + 1 && n_err == e0, "R6 extra bits ignored",
        n_valid - v0 + 16 * (n_err - e0), 1);
  endtask

  task automatic t_unsup_latency();
    int v0 = n_valid; int u0 = n_unsup;
    entry();
    send_bits(8'h83, 7);
    {dp_in, dn_in} = 2'b10;
    @(negedge clk); @(negedge clk);
    chk(!cmd_valid, "R1 no pulse before sync delay", cmd_valid, 0);
    @(negedge clk);
    chk(cmd_valid && cmd_unsupported, "R7 R1 valid and unsupported on third edge",
        {cmd_valid, cmd_unsupported}, 3);
    chk(cmd_code == 8'h83, "R3 R4 code MSB first", cmd_code, 8'h83);
    @(negedge clk);
    chk(!cmd_valid, "R4 single-cycle pulse", cmd_valid, 0);
    drive(2'b00);
    send_bits(8'hFF, 4);
    stop_seq();
    chk(n_valid == v0 + 1 && n_unsup == u0 + 1, "R7 trailing bits ignored",
        n_valid - v0, 1);
    t_trigger(8'h21);
    chk(last_code == 8'h21, "R7 next escape decodes", last_code, 8'h21);
  endtask

  task automatic t_ulps();
    int v0 = n_valid; int e0 = n_err;
    entry();
    send_bits(8'h1E, 8);
    chk(ulps_active == 1'b1, "R5 ulps entered", ulps_active, 1);
    chk(last_code == 8'h1E, "R5 ulps code", last_code, 8'h1E);
    drive(2'b01); drive(2'b00); drive(2'b10); drive(2'b01); drive(2'b00);
    chk(n_valid == v0 + 1 && n_err == e0, "R5 ulps quiet",
        n_valid - v0 + 16 * (n_err - e0), 1);
    drive(2'b10); drive(2'b00);
    chk(ulps_active == 1'b1, "R10 10 then 00 keeps ulps", ulps_active, 1);
    drive(2'b10);
    chk(ulps_active == 1'b1, "R10 10 alone keeps ulps", ulps_active, 1);
    drive(2'b11);
    chk(ulps_active == 1'b0, "R10 10 then 11 exits", ulps_active, 0);
  endtask

  task automatic t_abort();
    int v0 = n_valid; int e0 = n_err;
    entry();
    send_bits(8'hA5, 3);
    drive(2'b11);
    chk(n_err == e0 + 1, "R8 error on 11 mid command", n_err - e0, 1);
    chk(n_valid == v0, "R8 no valid on abort", n_valid - v0, 0);
    t_trigger(8'h5D);
    chk(last_code == 8'h5D, "R8 recovers after abort", last_code, 8'h5D);
  endtask

  task automatic t_hop();
    int v0 = n_valid; int e0 = n_err;
    entry();
    drive(2'b10);
    drive(2'b01);
    chk(n_err == e0 + 1, "R9 error on spacer-less hop", n_err - e0, 1);
    send_bits(8'h62, 8);
    chk(n_valid == v0, "R9 waits for 11 after hop", n_valid - v0, 0);
    drive(2'b11);
    t_trigger(8'hA0);
  endtask

  task automatic t_bad_entry();
    int v0 = n_valid; int e0 = n_err;
    drive(2'b11); drive(2'b10); drive(2'b01); drive(2'b00);
    send_bits(8'h62, 8);
    drive(2'b11);
    drive(2'b10); drive(2'b00); drive(2'b10); drive(2'b00);
    send_bits(8'h21, 8);
    stop_seq();
    chk(n_valid == v0 && n_err == e0, "R2 out-of-order entry decodes nothing",
        n_valid - v0, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_trigger(8'h62);
    t_unsup_latency();
    t_ulps();
    t_abort();
    t_hop();
    t_bad_entry();
    done = 1;
    $display("Result: errors=%0d of %0d checks", n_fail, n_checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", n_fail, n_checks);
      $finish;
    end
  end
endmodule